// File: doc/BRIEF.md
# SAR Converter Serial Output Port

This block is the device-side digital logic behind the serial port of a 16-bit successive-approximation converter. It watches three host lines: the conversion strobe `convst`, the serial input `sdi` and the serial clock `sclk`. It oversamples all three in the system clock domain and finds their edges there. A rising edge on the strobe starts a conversion of fixed length, counted in system clock cycles. The same edge takes a snapshot of the parallel `result` word, which stands in for the analog array. It also fixes how the word will leave the block.

There are two transfer styles. In select-gated operation the block leaves the line released until an active-low select asks for data. The select is the logical AND of `convst` and `sdi`, which covers both 3-wire and 4-wire hookups. In chained operation every device in a chain shares the strobe. Each device shifts out its own word and then forwards what it captured on `sdi`, so the chain behaves as one long shift register. Either style can put a low busy bit in front of the data.

Line release is modelled by a separate `sdo_oe` output. When `sdo_oe` is low the line is considered undriven.

Top module: `sar_serial_port`

## Requirements
- R1: On an accepted rising edge of `convst`, `sdi` high selects the select-gated style and `sdi` low selects the chained style. The same edge starts a conversion that ends `CONV_CYCLES` system cycles later.
- R2: In the select-gated style, `sdo_oe` goes low at the accepted strobe edge and stays low for the whole conversion, whatever `convst` or `sdi` do.
- R3: Select-gated, with the select high when the conversion ends: `sdo_oe` stays low until the select falls. At that point the MSB is driven, the next lower bit follows on each `sclk` falling edge, and `sdo_oe` drops after the 16th falling edge.
- R4: Select-gated, with the select low when the conversion ends: `sdo_oe` rises and `sdo` is driven 0 (busy bit) at that moment. The MSB follows on the first `sclk` falling edge, and `sdo_oe` drops after the 17th falling edge.
- R5: In the select-gated style, a rising select during a read drops `sdo_oe` at once, before the count of falling edges is reached.
- R6: The active-low select is `convst` AND `sdi`. Either line can gate the read: `convst` when `sdi` is held high (3-wire), or `sdi` when `convst` is held high (4-wire).
- R7: In the chained style, `sdo_oe` is 1 and `sdo` is 0 from the strobe edge onward. The `sclk` level at that edge sets the busy bit: 0 means no busy bit, so the MSB appears when the conversion ends; 1 means a 0 busy bit is held and the MSB comes on the first falling edge.
- R8: In the chained style, each `sclk` falling edge after the conversion shifts out the next bit and captures `sdi`. The captured bits appear MSB-first on `sdo`, directly after the block's own LSB, with no gap.
- R9: The transmitted word is `result`, straight binary and MSB first, taken at the accepted strobe edge. Later changes to `result` have no effect on the word sent (0x8000 mid-scale, 0xFFFF full-scale).
- R10: A rising edge on `convst` during a conversion is ignored. The conversion, its style and its busy choice carry on unchanged.
- R11: After reset, `sdo_oe` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all host lines are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| convst | input | 1 | Conversion strobe; also the select in 3-wire use |
| sdi | input | 1 | Style select at strobe edge; select in 4-wire use; chain data input |
| sclk | input | 1 | Serial clock; bits advance on its falling edge |
| result | input | DATA_W | Parallel conversion result, taken at the strobe edge |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | High when `sdo` is driven; low stands for three-state |

## Verification
The bench sweeps the word patterns that expose bit-order and edge-count errors (zero, mid-scale and its neighbour below, full-scale, a single LSB, a mixed pattern) through all four select-gated variants and both chained variants. An off-by-one in the falling-edge count shows up as a line released one bit early or driven one bit late. A busy bit in the wrong place shifts the whole word by one position. A chain that drops or repeats a bit at the boundary between the block's own word and the forwarded word corrupts the forwarded word. A further test aborts a read by raising the select. Another gives a second strobe mid-conversion with `sdi` high and changes `result` at the same time: a design that restarted would switch style and release the line, and a design that sampled late would send the changed word.

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              convst,
  input  logic              sdi,
  input  logic              sclk,
  input  logic [DATA_W-1:0] result,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int CNT_W = $clog2(CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W + 2);
  localparam logic [BIT_W-1:0] LAST_BUSY = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] LAST_PLAIN = BIT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] cv_sync, sdi_sync, sck_sync;
  logic cv_q, sck_q, sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_sync  <= '0;
      sdi_sync <= '0;
      sck_sync <= '0;
      cv_q     <= 1'b0;
      sck_q    <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      cv_sync  <= {cv_sync[SYNC_STAGES-2:0], convst};
      sdi_sync <= {sdi_sync[SYNC_STAGES-2:0], sdi};
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sclk};
      cv_q     <= cv_sync[SYNC_STAGES-1];
      sck_q    <= sck_sync[SYNC_STAGES-1];
      sel_q    <= cv_sync[SYNC_STAGES-1] & sdi_sync[SYNC_STAGES-1];
    end
  end

  wire cv_s     = cv_sync[SYNC_STAGES-1];
  wire sdi_s    = sdi_sync[SYNC_STAGES-1];
  wire sck_s    = sck_sync[SYNC_STAGES-1];
  wire sel_n    = cv_s & sdi_s;
  wire cv_rise  = cv_s & ~cv_q;
  wire sck_fall = ~sck_s & sck_q;
  wire sel_fall = ~sel_n & sel_q;
  wire sel_rise = sel_n & ~sel_q;

  logic             converting, mode_dc, busy, reading, cs_wait, sdo_r, oe_r;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bits;
  logic [DATA_W-1:0] hold, sh;

  wire shift_bit = busy ? sh[DATA_W-1] : sh[DATA_W-2];
  wire [BIT_W-1:0] last_bit = busy ? LAST_BUSY : LAST_PLAIN;
  wire eoc = converting && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      converting <= 1'b0;
      cnt        <= '0;
      mode_dc    <= 1'b0;
      busy       <= 1'b0;
      hold       <= '0;
      sh         <= '0;
      bits       <= '0;
      reading    <= 1'b0;
      cs_wait    <= 1'b0;
      sdo_r      <= 1'b0;
      oe_r       <= 1'b0;
    end else if (cv_rise && !converting) begin
      converting <= 1'b1;
      cnt        <= CNT_W'(CONV_CYCLES - 1);
      mode_dc    <= ~sdi_s;
      busy       <= ~sdi_s & sck_s;
      hold       <= result;
      bits       <= '0;
      reading    <= 1'b0;
      cs_wait    <= 1'b0;
      sdo_r      <= 1'b0;
      oe_r       <= ~sdi_s;
    end else if (converting) begin
      if (eoc) begin
        converting <= 1'b0;
        sh         <= hold;
        bits       <= '0;
        if (mode_dc) begin
          reading <= 1'b1;
          sdo_r   <= busy ? 1'b0 : hold[DATA_W-1];
        end else if (!sel_n) begin
          busy    <= 1'b1;
          reading <= 1'b1;
          oe_r    <= 1'b1;
          sdo_r   <= 1'b0;
        end else begin
          busy    <= 1'b0;
          cs_wait <= 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (mode_dc) begin
      if (reading && sck_fall) begin
        sdo_r <= shift_bit;
        sh    <= {sh[DATA_W-2:0], sdi_s};
      end
    end else if (sel_rise) begin
      oe_r    <= 1'b0;
      reading <= 1'b0;
    end else if (cs_wait && sel_fall) begin
      cs_wait <= 1'b0;
      reading <= 1'b1;
      oe_r    <= 1'b1;
      sdo_r   <= hold[DATA_W-1];
      sh      <= hold;
      bits    <= '0;
    end else if (reading && sck_fall) begin
      if (bits == last_bit) begin
        reading <= 1'b0;
        oe_r    <= 1'b0;
      end else begin
        sdo_r <= shift_bit;
        sh    <= {sh[DATA_W-2:0], 1'b0};
        bits  <= bits + 1'b1;
      end
    end
  end

  assign sdo    = sdo_r;
  assign sdo_oe = oe_r;

  a_r2_released_in_conversion: assert property (@(posedge clk) disable iff (!rst_n)
    (converting && !mode_dc) |-> !sdo_oe);

  a_r3_released_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_wait && !mode_dc) |-> !sdo_oe);

  a_r4_busy_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !mode_dc && !sel_n) |=> (sdo_oe && !sdo));

  a_r5_edge_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (reading && !mode_dc) |-> (bits <= LAST_BUSY));

  a_r7_chain_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
    mode_dc |-> sdo_oe);

  a_r10_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_rise && converting && cnt != '0) |=> (converting && $stable(mode_dc) && $stable(busy)));

endmodule

// File: tb/sar_serial_port_bench.sv
module sar_serial_port_bench;
  localparam int DW   = 16;
  localparam int CONV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convst = 1'b0, sdi = 1'b1, sclk = 1'b0;
  logic [DW-1:0] result = '0;
  logic sdo, sdo_oe;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sar_serial_port #(.DATA_W(DW), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) u_sar_serial_port (
    .clk(clk), .rst_n(rst_n), .convst(convst), .sdi(sdi), .sclk(sclk),
    .result(result), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic tk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fall_edge();
    sclk = 1'b1; tk(4);
    sclk = 1'b0; tk(6);
  endtask

  // R1 R2 R3 R4 R6 R9: select-gated read, 3-wire or 4-wire, with or without busy bit
  task automatic cs_read(input bit four_wire, input bit with_busy, input logic [DW-1:0] w);
    logic [DW-1:0] got;
    got = '0;
    result = w; sdi = 1'b1; sclk = 1'b0; convst = 1'b0; tk(6);
    convst = 1'b1; tk(6);
    chk("R2 released after strobe", {31'd0, sdo_oe}, 32'd0);
    if (with_busy) begin
      if (four_wire) sdi = 1'b0; else convst = 1'b0;
    end
    tk(CONV + 10);
    if (with_busy) begin
      chk("R4 busy bit driven low", {30'd0, sdo_oe, sdo}, 32'd2);
      for (int k = 1; k <= DW; k++) begin
        fall_edge();
        got[DW-k] = sdo;
      end
      chk("R4 R9 word after busy", {16'd0, got}, {16'd0, w});
      fall_edge();
      chk("R4 released after 17th fall", {31'd0, sdo_oe}, 32'd0);
    end else begin
      chk("R3 released until select", {31'd0, sdo_oe}, 32'd0);
      if (four_wire) sdi = 1'b0; else convst = 1'b0;
      tk(6);
      chk("R3 R6 driven on select fall", {31'd0, sdo_oe}, 32'd1);
      got[DW-1] = sdo;
      for (int k = 1; k < DW; k++) begin
        fall_edge();
        got[DW-1-k] = sdo;
      end
      chk("R3 R9 word without busy", {16'd0, got}, {16'd0, w});
      fall_edge();
      chk("R3 released after 16th fall", {31'd0, sdo_oe}, 32'd0);
    end
    convst = 1'b1; sdi = 1'b1; tk(6);
  endtask

  // R1 R7 R8 R9: chained transfer of own word followed by upstream word
  task automatic dc_read(input bit with_busy, input logic [DW-1:0] w, input logic [DW-1:0] up);
    logic [DW-1:0] own, fwd;
    int first;
    own = '0; fwd = '0;
    result = w; convst = 1'b0; sdi = 1'b0; sclk = with_busy; tk(6);
    convst = 1'b1; tk(6);
    chk("R7 chain drives low at start", {30'd0, sdo_oe, sdo}, 32'd2);
    tk(CONV + 10);
    if (with_busy) begin
      chk("R7 chain busy bit", {30'd0, sdo_oe, sdo}, 32'd2);
      first = 1;
    end else begin
      own[DW-1] = sdo;
      first = 0;
    end
    for (int k = 1; k <= 2 * DW - 1 + first; k++) begin
      sdi = (k <= DW) ? up[DW-k] : 1'b0;
      fall_edge();
      if (k <= DW - 1 + first) own[DW-1+first-k] = sdo;
      else fwd[2*DW-1+first-k] = sdo;
    end
    chk("R8 R9 chain own word", {16'd0, own}, {16'd0, w});
    chk("R8 chain forwarded word", {16'd0, fwd}, {16'd0, up});
    sdi = 1'b0; sclk = 1'b0; tk(6);
  endtask

  // R5: select raised mid-read
  task automatic abort_read(input logic [DW-1:0] w);
    result = w; sdi = 1'b1; sclk = 1'b0; convst = 1'b0; tk(6);
    convst = 1'b1; tk(CONV + 16);
    sdi = 1'b0; tk(6);
    for (int k = 0; k < 5; k++) fall_edge();
    chk("R5 still driven mid-read", {31'd0, sdo_oe}, 32'd1);
    sdi = 1'b1; tk(6);
    chk("R5 released on select rise", {31'd0, sdo_oe}, 32'd0);
    fall_edge();
    chk("R5 stays released", {31'd0, sdo_oe}, 32'd0);
  endtask

  // R10 R9: second strobe during conversion and late result change
  task automatic restart_ignored(input logic [DW-1:0] w);
    logic [DW-1:0] got;
    got = '0;
    result = w; convst = 1'b0; sdi = 1'b0; sclk = 1'b0; tk(6);
    convst = 1'b1; tk(6);
    result = ~w; tk(2);
    convst = 1'b0; sdi = 1'b1; tk(4);
    convst = 1'b1; tk(6);
    chk("R10 chain style kept", {31'd0, sdo_oe}, 32'd1);
    tk(CONV + 10);
    sdi = 1'b0;
    got[DW-1] = sdo;
    for (int k = 1; k < DW; k++) begin
      fall_edge();
      got[DW-1-k] = sdo;
    end
    chk("R10 R9 original sample sent", {16'd0, got}, {16'd0, w});
    result = w; tk(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] words [6];
    words[0] = 16'h0000; words[1] = 16'h8000; words[2] = 16'h7FFF;
    words[3] = 16'hFFFF; words[4] = 16'hA5C3; words[5] = 16'h0001;
    tk(3);
    chk("R11 reset released", {30'd0, sdo_oe, sdo}, 32'd0);
    rst_n = 1'b1; tk(4);
    chk("R11 idle after reset", {30'd0, sdo_oe, sdo}, 32'd0);
    for (int i = 0; i < 6; i++) begin
      cs_read(1'b0, 1'b0, words[i]);
      cs_read(1'b0, 1'b1, words[i]);
      cs_read(1'b1, 1'b0, words[i]);
      cs_read(1'b1, 1'b1, words[i]);
      dc_read(1'b0, words[i], ~words[i] ^ 16'h3C5A);
      dc_read(1'b1, words[i], words[i] ^ 16'h96E1);
    end
    abort_read(16'hC3A5);
    restart_ignored(16'h8001);
    cs_read(1'b0, 1'b0, 16'h1234);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule